// File: doc/BRIEF.md
# Staggered Four-Channel Chipping and Integrator Timing Generator

This block produces every digital timing signal needed by a multi-channel random-modulation front end. Each analog channel multiplies its input by a pseudo-random chipping sequence and integrates the product over fixed frames. Two integrators per channel take turns, so one can be cleared while the other is accumulating. The block runs from one master clock. For each channel it drives a chipping bit, a select that picks the active integrator, a clear pulse for the integrator that has just been sampled, a single-cycle sample strobe, and a convert strobe window for the external ADC.

Each chipping sequence is a Gold code. It is the XOR of two 6-bit maximal-length shift registers, and each channel uses its own starting phase for the second register. The code restarts on a frame-aligned grid of 63 frames. The frames of the channels are spread evenly over one frame period, so no two channels sample in the same cycle. An enable input freezes all state. A synchronous reset returns all state to its seeds.

Top module: `cs_timing_gen`

## Requirements
- R1: While `rst` is high, the next clock edge loads every seed and counter. After that edge `sel` is 0 on every channel and `smp`, `adc` and `irst` are 0. The first enabled cycle after reset is cycle t=0.
- R2: While `en` is low, no state advances. `chip` and `sel` keep their values, and `smp`, `adc` and `irst` are 0.
- R3: `chip[k]` equals bit 0 of register A XOR bit 0 of register B. Both registers shift right once per enabled cycle. The bit entering bit 5 is a[0]^a[1] for register A and b[0]^b[1]^b[2]^b[5] for register B. At t=0 register A holds 1 on every channel and register B holds k+1.
- R4: Every 3276 enabled cycles (63 frames of 52), both registers of every channel are reloaded with their seeds.
- R5: A frame is 52 enabled cycles long. Channel k ends a frame at every t with t mod 52 equal to (13k+51) mod 52.
- R6: `smp[k]` is a one-cycle pulse in the last cycle of each frame. It is suppressed for the partial first frame of channels 1 to 3. The first pulse therefore comes at t=51 for channel 0 and at t=13k+51 for channel k.
- R7: `sel[k]` toggles after every frame end, partial frames included. Its value is the parity of the number of frame ends so far.
- R8: `adc[k]` is high for the 26 enabled cycles that follow each sample pulse and low at all other times.
- R9: `irst[k]` is high only in the first enabled cycle after each sample pulse.
- R10: At most one channel asserts `smp` in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable |
| chip | output | NUM_CH | Chipping bit per channel |
| sel | output | NUM_CH | Integrator select per channel (1: B integrates, A clears) |
| irst | output | NUM_CH | Clear pulse for the integrator just sampled |
| smp | output | NUM_CH | Sample strobe, last cycle of frame |
| adc | output | NUM_CH | Convert strobe window after the sample |

## Verification
The bench uses the default parameters: four channels, 52-cycle frames, a 13-cycle stagger and a 26-cycle hold. With these values the run reaches the 3276-cycle code restart and a partial first frame on each of the staggered channels. The enable pattern pauses the block in the middle of frames and in the middle of hold windows. A second reset issued mid-run shows that the frame grid and the code phase start again from t=0.

// File: rtl/cs_tg_pkg.sv
package cs_tg_pkg;
    localparam int LFSR_W = 6;
    localparam logic [LFSR_W-1:0] TAPS_A = 6'b000011;
    localparam logic [LFSR_W-1:0] TAPS_B = 6'b100111;

    typedef logic [LFSR_W-1:0] lfsr_t;

    function automatic lfsr_t lfsr_step(input lfsr_t s, input lfsr_t taps);
        return {^(s & taps), s[LFSR_W-1:1]};
    endfunction
endpackage

// File: rtl/cs_tg_gold.sv
module cs_tg_gold
    import cs_tg_pkg::*;
#(
    parameter lfsr_t SEED_A = 6'd1,
    parameter lfsr_t SEED_B = 6'd1
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic restart,
    output logic chip
);
    typedef struct packed {
        lfsr_t a;
        lfsr_t b;
    } gold_st_t;

    gold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst || (en && restart)) begin
            st_d.a = SEED_A;
            st_d.b = SEED_B;
        end else if (en) begin
            st_d.a = lfsr_step(st_q.a, TAPS_A);
            st_d.b = lfsr_step(st_q.b, TAPS_B);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign chip = st_q.a[0] ^ st_q.b[0];
endmodule

// File: rtl/cs_tg_frame.sv
module cs_tg_frame #(
    parameter int FRAME_LEN = 52,
    parameter int HOLD_LEN  = 26,
    parameter int PHASE0    = 0,
    parameter bit FULL0     = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic sel,
    output logic irst,
    output logic smp,
    output logic adc
);
    localparam int PH_W = $clog2(FRAME_LEN);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_LEN - 1);
    localparam logic [PH_W-1:0] PH_INIT = PH_W'(PHASE0);
    localparam logic [PH_W-1:0] PH_HOLD = PH_W'(HOLD_LEN);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            sel;
        logic            full;
        logic            sampled;
    } frm_st_t;

    frm_st_t st_d, st_q;
    logic    at_end;
    logic    smp_w;

    always_comb begin
        at_end = (st_q.phase == PH_LAST);
        smp_w  = en && at_end && st_q.full;
        st_d   = st_q;
        if (rst) begin
            st_d.phase   = PH_INIT;
            st_d.sel     = 1'b0;
            st_d.full    = FULL0;
            st_d.sampled = 1'b0;
        end else if (en) begin
            st_d.phase   = at_end ? '0 : st_q.phase + 1'b1;
            st_d.sel     = st_q.sel ^ at_end;
            st_d.full    = st_q.full | at_end;
            st_d.sampled = st_q.sampled | smp_w;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sel  = st_q.sel;
    assign smp  = smp_w;
    assign adc  = en && st_q.sampled && (st_q.phase < PH_HOLD);
    assign irst = en && st_q.sampled && (st_q.phase == '0);
endmodule

// File: rtl/cs_timing_gen.sv
module cs_timing_gen
    import cs_tg_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int FRAME_LEN   = 52,
    parameter int HOLD_LEN    = 26,
    parameter int STAGGER     = 13,
    parameter int CODE_FRAMES = 63
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic [NUM_CH-1:0] chip,
    output logic [NUM_CH-1:0] sel,
    output logic [NUM_CH-1:0] irst,
    output logic [NUM_CH-1:0] smp,
    output logic [NUM_CH-1:0] adc
);
    localparam int CODE_LEN = FRAME_LEN * CODE_FRAMES;
    localparam int CNT_W    = $clog2(CODE_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CODE_LEN - 1);

    logic [CNT_W-1:0] code_d, code_q;
    logic             restart;

    always_comb begin
        restart = (code_q == CNT_LAST);
        code_d  = code_q;
        if (rst)
            code_d = '0;
        else if (en)
            code_d = restart ? '0 : code_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        code_q <= code_d;
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        localparam int OFS = (STAGGER * k) % FRAME_LEN;
        localparam int PH0 = (FRAME_LEN - OFS) % FRAME_LEN;

        cs_tg_gold #(
            .SEED_A(lfsr_t'(1)),
            .SEED_B(lfsr_t'(k + 1))
        ) u_gold (
            .clk    (clk),
            .rst    (rst),
            .en     (en),
            .restart(restart),
            .chip   (chip[k])
        );

        cs_tg_frame #(
            .FRAME_LEN(FRAME_LEN),
            .HOLD_LEN (HOLD_LEN),
            .PHASE0   (PH0),
            .FULL0    (PH0 == 0)
        ) u_frame (
            .clk (clk),
            .rst (rst),
            .en  (en),
            .sel (sel[k]),
            .irst(irst[k]),
            .smp (smp[k]),
            .adc (adc[k])
        );
    end
endmodule

// File: rtl/cs_timing_gen_chk.sv
module cs_timing_gen_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [NUM_CH-1:0] chip,
    input logic [NUM_CH-1:0] sel,
    input logic [NUM_CH-1:0] irst,
    input logic [NUM_CH-1:0] smp,
    input logic [NUM_CH-1:0] adc
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (sel == '0) && (smp == '0) && (adc == '0) && (irst == '0));

    assert_no_coincident_sample_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(smp));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        assert_pause_holds_R2: assert property (@(posedge clk) disable iff (rst)
            !en |=> $stable(chip[k]) && $stable(sel[k]));

        assert_single_sample_R6: assert property (@(posedge clk) disable iff (rst)
            smp[k] |=> !smp[k]);

        assert_sel_flips_R7: assert property (@(posedge clk) disable iff (rst)
            smp[k] |=> sel[k] != $past(sel[k]));

        assert_no_sample_in_hold_R8: assert property (@(posedge clk) disable iff (rst)
            !(smp[k] && adc[k]));

        assert_clear_in_window_R9: assert property (@(posedge clk) disable iff (rst)
            irst[k] |-> adc[k]);
    end
endmodule

bind cs_timing_gen cs_timing_gen_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .chip(chip),
    .sel (sel),
    .irst(irst),
    .smp (smp),
    .adc (adc)
);

// File: tb/cs_timing_gen_tb_top.sv
`timescale 1ns/1ps
module cs_timing_gen_tb_top;
    localparam int NCH = 4;
    localparam int FL  = 52;
    localparam int HL  = 26;
    localparam int ST  = 13;
    localparam int CL  = 3276;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [NCH-1:0] chip, sel, irst, smp, adc;

    int n_checks = 0;
    int n_fail   = 0;

    int t;
    int la[NCH];
    int lb[NCH];
    bit valid = 0;

    always #4 clk = ~clk;

    cs_timing_gen dut_i (
        .clk(clk), .rst(rst), .en(en),
        .chip(chip), .sel(sel), .irst(irst), .smp(smp), .adc(adc)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s t=%0d actual=%0d expected=%0d", tag, t, act, exp);
        end
    endtask

    function automatic int step_a(input int s);
        return (s >> 1) | (((s ^ (s >> 1)) & 1) << 5);
    endfunction

    function automatic int step_b(input int s);
        return (s >> 1) | (((s ^ (s >> 1) ^ (s >> 2) ^ (s >> 5)) & 1) << 5);
    endfunction

    task automatic model_reset();
        t = 0;
        for (int k = 0; k < NCH; k++) begin
            la[k] = 1;
            lb[k] = k + 1;
        end
        valid = 1;
    endtask

    // compare all outputs against the model, then advance the model
    task automatic cycle(input bit r, input bit e);
        @(negedge clk);
        rst = r;
        en  = e;
        #1;
        if (valid) begin
            for (int k = 0; k < NCH; k++) begin
                int o, ph, first_s, e_smp, e_adc, e_irst, e_sel;
                bit full, sampled;
                o       = (FL - (ST * k) % FL) % FL;
                ph      = (t + o) % FL;
                full    = (t >= ST * k);
                first_s = (k == 0) ? FL - 1 : ST * k + FL - 1;
                sampled = (t > first_s);
                e_smp   = (e && ph == FL - 1 && full) ? 1 : 0;
                e_adc   = (e && sampled && ph < HL) ? 1 : 0;
                e_irst  = (e && sampled && ph == 0) ? 1 : 0;
                e_sel   = ((t + o) / FL) & 1;
                if (!e) begin
                    check("R2 pause smp", int'(smp[k]), 0);
                    check("R2 pause adc", int'(adc[k]), 0);
                    check("R2 pause irst", int'(irst[k]), 0);
                end else begin
                    check("R5 R6 smp", int'(smp[k]), e_smp);
                    check("R8 adc", int'(adc[k]), e_adc);
                    check("R9 irst", int'(irst[k]), e_irst);
                end
                check(t >= CL ? "R4 chip after restart" : "R3 chip",
                      int'(chip[k]), (la[k] ^ lb[k]) & 1);
                check(t == 0 ? "R1 sel after reset" : "R7 sel", int'(sel[k]), e_sel);
            end
            check("R10 single sampler", (int'($countones(smp)) <= 1) ? 1 : 0, 1);
        end
        @(posedge clk);
        if (r) model_reset();
        else if (valid && e) begin
            t++;
            for (int k = 0; k < NCH; k++) begin
                la[k] = step_a(la[k]);
                lb[k] = step_b(lb[k]);
            end
            if (t % CL == 0)
                for (int k = 0; k < NCH; k++) begin
                    la[k] = 1;
                    lb[k] = k + 1;
                end
        end
    endtask

    bit wd_hit = 0;

    initial begin
        fork
            begin
                for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0);
                @(negedge clk);
                #1;
                check("R1 reset strobes", int'({smp, adc, irst}), 0);
                check("R1 reset sel", int'(sel), 0);
                for (int i = 0; i < 7600; i++)
                    cycle(1'b0, !((i % 97) >= 91 || (i > 3000 && i < 3010)));
                for (int i = 0; i < 2; i++) cycle(1'b1, 1'b1);
                for (int i = 0; i < 400; i++) cycle(1'b0, (i % 41) != 40);
            end
            begin
                repeat (200000) @(posedge clk);
                wd_hit = 1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule